// File: doc/BRIEF.md
# Three-Wire Serial Register Slave with Motion Burst

This block is the slave end of a shared three-wire serial bus: an active-low select, a serial clock from the master, and one data line that both sides take turns driving. Every transaction is two bytes. The first byte carries the direction in its top bit (1 = write, 0 = read) and a 7-bit register address in the remaining bits, most significant first. On a write the master then sends a data byte. On a read the slave returns a data byte and drives the line only for that byte. The clock, select and data pins are brought into the faster system clock through two-flop synchronisers, and clock edges are detected there.

The block holds the fixed identity values and the writable control registers. Live motion and status bytes come from the blocks that own them. Write strobes for the motion-clear and control addresses, and a read strobe carrying the decoded read address, go back to those owners. Reading the burst address captures a snapshot of all status bytes and streams them back to back until select rises. A key written to the reset address produces a one-cycle soft reset.

Top module: `serial_reg_slave`

## Requirements
- R1: The slave samples the data line on rising serial clock edges and updates its output bit only after falling edges. Read data goes out most significant bit first. The output enable is high only during the data byte of a read and is low throughout any write.
- R2: Reads return fixed values: address 0x00 gives 0x12, 0x01 gives 0x01, 0x3e gives 0x26, and 0x3f gives 0xfe, which is the bitwise inverse of the 0x01 revision.
- R3: Writes to 0x0d, 0x19 and 0x22 update the control registers. These registers appear on ctrl_o, ctrl2_o and led_mode_o and read back at the same addresses. Writes to 0x0d, 0x19, 0x22 and 0x02 (motion clear) each give a one-cycle wr_stb_o with the address and data.
- R4: Writes to any other address have no effect and produce no wr_stb_o. Reads from addresses with no register return 0x00.
- R5: While select is high, the output enable drops within three system clocks, and clock and data activity is ignored.
- R6: Raising select part-way through a transaction discards it. The next transaction is decoded from its first bit.
- R7: A read of address 0x63 starts a burst. The burst returns, in order, status bytes 0 to 6 of stat_i (X delta, Y delta, quality, shutter high, shutter low, maximum pixel, pixel sum), with no address between bytes. Each status byte k sits at stat_i[8k+7:8k]. The bytes are taken from stat_i as it stands when the last address bit is received.
- R8: After the seventh burst byte, the pixel-sum byte (status byte 6) is repeated for every further byte.
- R9: During a burst, bits the master shifts in are not decoded, so they produce no write. Only after select has been raised does the port accept a new transaction.
- R10: Writing 0x5a to address 0x3a gives a soft_rst_o pulse exactly one cycle wide. The same write returns the control registers to 0x00, 0x08 and 0x00. Any other value written to 0x3a does nothing.
- R11: Address 0x02 reads motion_i, and addresses 0x03 to 0x09 read status bytes 0 to 6. Each read gives a one-cycle rd_stb_o with rd_addr_o set to the address read.
- R12: After reset, the output enable is low and the control registers hold 0x00, 0x08 and 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master, idle high |
| sel_n_i | input | 1 | Active-low select |
| sdio_i | input | 1 | Data line as seen at the pad input |
| sdio_o | output | 1 | Data bit driven by the slave |
| sdio_oe_o | output | 1 | Pad output enable for sdio_o |
| motion_i | input | 8 | Motion flag byte from its owner |
| stat_i | input | 8*NSTAT | Status bytes, byte k at bits 8k+7:8k |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 7 | Address of the strobed write |
| wr_data_o | output | 8 | Data of the strobed write |
| rd_stb_o | output | 1 | One-cycle read strobe at address decode |
| rd_addr_o | output | 7 | Address of the strobed read |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| ctrl_o | output | 8 | Control register at 0x0d |
| ctrl2_o | output | 8 | Resolution control register at 0x19 |
| led_mode_o | output | 8 | LED mode register at 0x22 |

## Verification
The assertions assume that the serial clock stays in each phase for several system clocks, so that a rising edge and a falling edge are never detected in the same cycle. They also assume that select is stable whenever a serial clock edge arrives. The bench drives each serial half period for eight system clocks. It moves the data line and select only while the serial clock is low, or while it is idle high with no edge near. It changes its inputs one time unit after a system clock edge, and it samples the slave's output late in each low phase.

// File: rtl/serial_reg_slave.sv
module serial_reg_slave #(
  parameter int          NSTAT      = 7,
  parameter logic [7:0]  PROD_ID    = 8'h12,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [7:0]  PROD_ID2   = 8'h26,
  parameter logic [7:0]  CTRL2_INIT = 8'h08,
  parameter logic [7:0]  RST_KEY    = 8'h5a,
  parameter logic [6:0]  BURST_ADDR = 7'h63
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               sel_n_i,
  input  logic               sdio_i,
  output logic               sdio_o,
  output logic               sdio_oe_o,
  input  logic [7:0]         motion_i,
  input  logic [8*NSTAT-1:0] stat_i,
  output logic               wr_stb_o,
  output logic [6:0]         wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               rd_stb_o,
  output logic [6:0]         rd_addr_o,
  output logic               soft_rst_o,
  output logic [7:0]         ctrl_o,
  output logic [7:0]         ctrl2_o,
  output logic [7:0]         led_mode_o
);
  localparam int IDX_W = (NSTAT > 1) ? $clog2(NSTAT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSTAT - 1);
  localparam logic [6:0] A_MOT = 7'h02, A_STAT = 7'h03, A_CTRL = 7'h0d,
                         A_CTRL2 = 7'h19, A_LED = 7'h22, A_RST = 7'h3a,
                         A_PID2 = 7'h3e, A_INV = 7'h3f;

  logic [2:0] sclk_q;
  logic [1:0] sel_q, din_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 3'b111; sel_q <= 2'b11; din_q <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      sel_q  <= {sel_q[0], sel_n_i};
      din_q  <= {din_q[0], sdio_i};
    end

  wire sel_s = sel_q[1];
  wire din   = din_q[1];
  wire rise  = sclk_q[1] & ~sclk_q[2];
  wire fall  = ~sclk_q[1] & sclk_q[2];

  logic [3:0]         bitcnt;
  logic [6:0]         sh, adr;
  logic [7:0]         tx, rdata;
  logic [8*NSTAT-1:0] snap;
  logic [IDX_W-1:0]   idx;
  logic               is_wr, rd_act, burst;

  wire [6:0]       addr7    = {sh[5:0], din};
  wire [7:0]       wd       = {sh[6:0], din};
  wire [IDX_W-1:0] idx_nxt  = (idx == LAST) ? idx : idx + 1'b1;

  always_comb begin
    rdata = 8'h00;
    case (addr7)
      7'h00:   rdata = PROD_ID;
      7'h01:   rdata = REV_ID;
      A_MOT:   rdata = motion_i;
      A_CTRL:  rdata = ctrl_o;
      A_CTRL2: rdata = ctrl2_o;
      A_LED:   rdata = led_mode_o;
      A_PID2:  rdata = PROD_ID2;
      A_INV:   rdata = ~REV_ID;
      default: rdata = 8'h00;
    endcase
    for (int k = 0; k < NSTAT; k++)
      if (addr7 == A_STAT + 7'(k)) rdata = stat_i[8*k +: 8];
  end

  assign rd_addr_o = adr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0; sh <= '0; adr <= '0; tx <= '0; snap <= '0; idx <= '0;
      is_wr <= 1'b0; rd_act <= 1'b0; burst <= 1'b0;
      sdio_o <= 1'b0; sdio_oe_o <= 1'b0;
      wr_stb_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
      rd_stb_o <= 1'b0; soft_rst_o <= 1'b0;
      ctrl_o <= 8'h00; ctrl2_o <= CTRL2_INIT; led_mode_o <= 8'h00;
    end else begin
      wr_stb_o <= 1'b0; rd_stb_o <= 1'b0; soft_rst_o <= 1'b0;
      if (sel_s) begin
        bitcnt <= '0; is_wr <= 1'b0; rd_act <= 1'b0; burst <= 1'b0;
        idx <= '0; sdio_oe_o <= 1'b0;
      end else begin
        if (rise) begin
          sh <= {sh[5:0], din};
          if (burst) begin
            if (bitcnt == 4'd15) begin
              bitcnt <= 4'd8;
              idx    <= idx_nxt;
              tx     <= snap[8*idx_nxt +: 8];
            end else bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd7) begin
            bitcnt <= 4'd8;
            adr    <= addr7;
            if (sh[6]) is_wr <= 1'b1;
            else begin
              rd_act <= 1'b1; rd_stb_o <= 1'b1;
              if (addr7 == BURST_ADDR) begin
                burst <= 1'b1; idx <= '0; snap <= stat_i; tx <= stat_i[7:0];
              end else tx <= rdata;
            end
          end else if (bitcnt == 4'd15) begin
            bitcnt <= '0; rd_act <= 1'b0; is_wr <= 1'b0;
            if (is_wr) begin
              case (adr)
                A_MOT:   begin wr_stb_o <= 1'b1; end
                A_CTRL:  begin wr_stb_o <= 1'b1; ctrl_o <= wd; end
                A_CTRL2: begin wr_stb_o <= 1'b1; ctrl2_o <= wd; end
                A_LED:   begin wr_stb_o <= 1'b1; led_mode_o <= wd; end
                A_RST:
                  if (wd == RST_KEY) begin
                    soft_rst_o <= 1'b1;
                    ctrl_o <= 8'h00; ctrl2_o <= CTRL2_INIT; led_mode_o <= 8'h00;
                  end
                default: ;
              endcase
              if (adr == A_MOT || adr == A_CTRL || adr == A_CTRL2 || adr == A_LED) begin
                wr_addr_o <= adr; wr_data_o <= wd;
              end
            end
          end else bitcnt <= bitcnt + 4'd1;
        end
        if (fall) begin
          if (rd_act) begin
            sdio_oe_o <= 1'b1; sdio_o <= tx[7]; tx <= {tx[6:0], 1'b0};
          end else sdio_oe_o <= 1'b0;
        end
      end
    end

  assert_deselect_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> !sdio_oe_o);
  assert_write_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> !sdio_oe_o);
  assert_bit_moves_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdio_o));
  assert_burst_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst |-> !wr_stb_o);
  assert_burst_idx_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);
  assert_soft_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);
endmodule

// File: tb/tb_serial_reg_slave.sv
module tb_serial_reg_slave;
  localparam int NSTAT = 7;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, sel_n = 1'b1, sdi = 1'b0;
  logic sdio_o, sdio_oe;
  logic [7:0] motion = 8'h80;
  logic [8*NSTAT-1:0] stat;
  logic wr_stb, rd_stb, soft_rst;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, ctrl, ctrl2, led;

  int nchk = 0, nerr = 0;
  int wr_cnt = 0, rd_cnt = 0, soft_cnt = 0;
  logic [6:0] lw_addr, lr_addr;
  logic [7:0] lw_data;

  always #5 clk = ~clk;

  serial_reg_slave #(.NSTAT(NSTAT)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .sdio_i(sdi),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .motion_i(motion), .stat_i(stat),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_stb_o(rd_stb), .rd_addr_o(rd_addr), .soft_rst_o(soft_rst),
    .ctrl_o(ctrl), .ctrl2_o(ctrl2), .led_mode_o(led));

  always @(posedge clk) if (rst_n) begin
    if (wr_stb) begin wr_cnt++; lw_addr = wr_addr; lw_data = wr_data; end
    if (rd_stb) begin rd_cnt++; lr_addr = rd_addr; end
    if (soft_rst) soft_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] got, output logic oe_all);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; sdi = b[i];
      wclk(HALF);
      got[i] = sdio_o; oe_all &= sdio_oe;
      sclk = 1'b1;
      wclk(HALF);
    end
  endtask

  task automatic start();  sel_n = 1'b0; wclk(4); endtask
  task automatic stop();   wclk(2); sel_n = 1'b1; wclk(10); endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d, output logic oe_all);
    logic [7:0] g; logic o;
    start();
    xfer({1'b0, a}, g, o);
    xfer(8'h00, d, oe_all);
    stop();
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, output logic oe_any);
    logic [7:0] g; logic o1, o2;
    start();
    xfer({1'b1, a}, g, o1);
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; sdi = d[i]; wclk(HALF);
      oe_any |= sdio_oe;
      sclk = 1'b1; wclk(HALF);
    end
    o2 = o1;
    stop();
  endtask

  task automatic t_reset();
    chk("R12 oe after reset", sdio_oe, 0);
    chk("R12 ctrl default", ctrl, 8'h00);
    chk("R12 ctrl2 default", ctrl2, 8'h08);
    chk("R12 led default", led, 8'h00);
  endtask

  task automatic t_ids();
    logic [7:0] d; logic o;
    rd(7'h00, d, o); chk("R2 id 0x00", d, 8'h12);
    chk("R1 oe during read data", o, 1);
    rd(7'h01, d, o); chk("R2 rev 0x01", d, 8'h01);
    rd(7'h3e, d, o); chk("R2 id 0x3e", d, 8'h26);
    rd(7'h3f, d, o); chk("R2 inverse rev 0x3f", d, 8'hfe);
    chk("R1 oe released after read", sdio_oe, 0);
  endtask

  task automatic t_status();
    logic [7:0] d; logic o; int c0;
    c0 = rd_cnt;
    rd(7'h05, d, o); chk("R11 status byte 2", d, 8'ha2);
    chk("R11 rd strobe addr", lr_addr, 7'h05);
    rd(7'h09, d, o); chk("R11 status byte 6", d, 8'ha6);
    rd(7'h02, d, o); chk("R11 motion read", d, 8'h80);
    chk("R11 rd strobe count", rd_cnt - c0, 3);
  endtask

  task automatic t_write();
    logic [7:0] d; logic o; int c0;
    c0 = wr_cnt;
    wr(7'h0d, 8'h01, o); chk("R1 oe low in write", o, 0);
    chk("R3 ctrl_o", ctrl, 8'h01);
    wr(7'h19, 8'h1b, o); chk("R3 ctrl2_o", ctrl2, 8'h1b);
    wr(7'h22, 8'h80, o); chk("R3 led_mode_o", led, 8'h80);
    rd(7'h19, d, o); chk("R3 ctrl2 readback", d, 8'h1b);
    wr(7'h02, 8'h77, o);
    chk("R3 strobe addr", lw_addr, 7'h02);
    chk("R3 strobe data", lw_data, 8'h77);
    chk("R3 strobe count", wr_cnt - c0, 4);
  endtask

  task automatic t_reserved();
    logic [7:0] d; logic o; int c0;
    c0 = wr_cnt;
    wr(7'h10, 8'h55, o);
    chk("R4 no strobe on reserved write", wr_cnt - c0, 0);
    rd(7'h10, d, o); chk("R4 reserved read zero", d, 8'h00);
    rd(7'h0d, d, o); chk("R4 ctrl untouched", d, 8'h01);
  endtask

  task automatic t_deselect();
    logic [15:0] pat; int c0;
    pat = 16'h8dff; c0 = wr_cnt;
    sel_n = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b0; sdi = pat[i]; wclk(HALF);
      if (i == 4) chk("R5 oe low while deselected", sdio_oe, 0);
      sclk = 1'b1; wclk(HALF);
    end
    chk("R5 no write while deselected", wr_cnt - c0, 0);
    chk("R5 ctrl unchanged", ctrl, 8'h01);
  endtask

  task automatic t_abort();
    logic [7:0] d; logic o;
    start();
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; sdi = 1'b1; wclk(HALF); sclk = 1'b1; wclk(HALF);
    end
    stop();
    rd(7'h00, d, o); chk("R6 clean decode after abort", d, 8'h12);
  endtask

  task automatic t_burst();
    logic [7:0] g; logic o; int c0;
    logic [7:0] exp;
    c0 = wr_cnt;
    start();
    xfer(8'h63, g, o);
    for (int k = 0; k < NSTAT; k++) stat[8*k +: 8] = 8'h50 + 8'(k);
    for (int n = 0; n < 10; n++) begin
      xfer(8'h00, g, o);
      exp = (n < NSTAT) ? 8'ha0 + 8'(n) : 8'ha6;
      if (n < NSTAT) chk($sformatf("R7 burst byte %0d", n), g, exp);
      else           chk($sformatf("R8 repeat byte %0d", n), g, exp);
    end
    xfer(8'h8d, g, o); chk("R9 burst ignores address", g, 8'ha6);
    xfer(8'h33, g, o); chk("R9 burst keeps streaming", g, 8'ha6);
    stop();
    chk("R9 no write during burst", wr_cnt - c0, 0);
    chk("R9 ctrl unchanged by burst", ctrl, 8'h01);
    rd(7'h00, g, o); chk("R9 port usable after select", g, 8'h12);
    for (int k = 0; k < NSTAT; k++) stat[8*k +: 8] = 8'ha0 + 8'(k);
  endtask

  task automatic t_softrst();
    logic o; int s0;
    s0 = soft_cnt;
    wr(7'h3a, 8'h11, o);
    chk("R10 wrong key no pulse", soft_cnt - s0, 0);
    chk("R10 wrong key ctrl kept", ctrl, 8'h01);
    wr(7'h3a, 8'h5a, o);
    chk("R10 pulse one cycle", soft_cnt - s0, 1);
    chk("R10 ctrl default", ctrl, 8'h00);
    chk("R10 ctrl2 default", ctrl2, 8'h08);
    chk("R10 led default", led, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int k = 0; k < NSTAT; k++) stat[8*k +: 8] = 8'ha0 + 8'(k);
    wclk(5); rst_n = 1'b1; wclk(5);
    t_reset();
    t_ids();
    t_status();
    t_write();
    t_reserved();
    t_deselect();
    t_abort();
    t_burst();
    t_softrst();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule